// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block moves a clock generator into and out of its low-power state. An active-low power-down request arrives asynchronously. It is first brought into the reference clock domain. Every clock output gate is then closed on a falling edge of the reference clock. The VCO and crystal oscillator enables are dropped only after all gates have been held closed for a fixed number of cycles. On wake-up the oscillator and VCO restart first. Then a programmable settle count runs, and only after it completes do the gates reopen, again on a falling edge. The gated outputs therefore never carry a shortened pulse.

The gates also apply a per-output enable mask, so a disabled output is held low. A three-state request closes every gate whatever the mask holds. While the block is powered down, the mask and the three-state request have no effect.

The controller has four states:
- `ST_RUN`: clocks are running.
- `ST_STOPPING`: the gates are closed and the block waits for the outputs to settle low.
- `ST_OFF`: the VCO and the oscillator are disabled.
- `ST_WAKE`: the oscillator and VCO are running and the settle count is in progress.

It has five transitions:
- RUN→STOPPING when the synchronized request goes low.
- STOPPING→OFF when the stop wait expires.
- OFF→WAKE when the synchronized request goes high.
- WAKE→RUN when the settle count is reached.
- WAKE→STOPPING when the request returns low during wake.

Top module: `pwrdn_seq`

## Requirements
- R1: `pd_n` passes through a two-flop synchronizer before it acts. With `pd_n` driven low between clock edges, the gates are still open after the second and third following rising edges.
- R2: Every change of `gate_en` happens while `clk` is low. Gates close on the falling edge that follows the rising edge where the block enters `ST_STOPPING`; with `pd_n` dropped, `gate_en` reads 0 after the fourth rising edge.
- R3: `vco_en` and `osc_en` stay high while the gates are closed for STOP_WAIT (default 4) cycles. Both fall together at the seventh rising edge after `pd_n` drops, and never while any gate is open.
- R4: While `osc_en` or `vco_en` is low, `gate_en` is all zero.
- R5: After `pd_n` rises, `vco_en` and `osc_en` return at the third rising edge. The gates reopen only after `settle_cycles` further cycles, first visible at rising edge `settle_cycles`+5, with a bounded wake latency of `settle_cycles`+5 cycles.
- R6: In `ST_RUN`, bit i of `gate_en` equals bit i of `out_mask`, half a cycle after the mask changes. A 0 in the mask holds that output low.
- R7: While `tristate` is 1, `gate_en` is all zero. Clearing it restores the mask.
- R8: If `pd_n` falls again during `ST_WAKE`, the gates never open and the block returns to `ST_OFF`.
- R9: In `ST_OFF`, changes to `out_mask` and `tristate` leave `gate_en` at 0.
- R10: During reset, `gate_en` is 0 and `vco_en` and `osc_en` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| out_mask | input | NOUT | Per-output enable, 1 = running |
| tristate | input | 1 | 1 forces every gate closed |
| settle_cycles | input | SW | Wake settle count in clock cycles |
| gate_en | output | NOUT | Per-output clock gate, changes on falling edges only |
| vco_en | output | 1 | VCO enable |
| osc_en | output | 1 | Crystal oscillator enable |

## Verification
On every cycle, the assertions check four properties:
- gates move only while the clock is low;
- no gate is open while the oscillator or VCO is off;
- the oscillator and VCO are disabled only after a cycle in which every gate was already closed;
- the three-state request keeps all gates closed.

The exact edge counts can only be shown by the bench's timed scenarios: the synchronizer delay, the stop wait, the settle count, and the wake that is aborted part-way. The same holds for the mask being ignored while powered down.

// File: rtl/pwrdn_seq_pkg.sv
package pwrdn_seq_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_STOPPING = 2'd1,
        ST_OFF      = 2'd2,
        ST_WAKE     = 2'd3
    } pd_state_t;
endpackage

// File: rtl/pd_sync.sv
module pd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= 1'b1;
            sync_out <= 1'b1;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import pwrdn_seq_pkg::*;
#(
    parameter int SW        = 16,
    parameter int STOP_WAIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_req,
    input  logic [SW-1:0] settle_cycles,
    output logic          gates_allowed,
    output logic          vco_en,
    output logic          osc_en
);
    localparam int SWW = $clog2(STOP_WAIT + 1);
    localparam int CW  = (SW > SWW) ? SW : SWW;
    localparam logic [CW-1:0] STOP_LAST = CW'(STOP_WAIT - 1);

    pd_state_t     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (!run_req) begin
                    state_d = ST_STOPPING;
                    cnt_d   = '0;
                end
            end
            ST_STOPPING: begin
                if (cnt_q >= STOP_LAST) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_OFF: begin
                if (run_req) begin
                    state_d = ST_WAKE;
                    cnt_d   = '0;
                end
            end
            ST_WAKE: begin
                if (!run_req) begin
                    state_d = ST_STOPPING;
                    cnt_d   = '0;
                end else if (cnt_q >= CW'(settle_cycles)) begin
                    state_d = ST_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_STOPPING;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        gates_allowed = 1'b0;
        vco_en        = 1'b1;
        osc_en        = 1'b1;
        unique case (state_q)
            ST_RUN:      gates_allowed = 1'b1;
            ST_STOPPING: gates_allowed = 1'b0;
            ST_OFF: begin
                vco_en = 1'b0;
                osc_en = 1'b0;
            end
            ST_WAKE:     gates_allowed = 1'b0;
            default:     gates_allowed = 1'b0;
        endcase
    end
endmodule

// File: rtl/pd_gate_bank.sv
module pd_gate_bank #(
    parameter int NOUT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            allow,
    input  logic            tristate,
    input  logic [NOUT-1:0] out_mask,
    output logic [NOUT-1:0] gate_en
);
    for (genvar g = 0; g < NOUT; g++) begin : g_gate
        // falling-edge register: the gate moves while the clock is low
        always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) gate_en[g] <= 1'b0;
            else        gate_en[g] <= allow & out_mask[g] & ~tristate;
        end
    end
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
    parameter int NOUT      = 8,
    parameter int SW        = 16,
    parameter int STOP_WAIT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pd_n,
    input  logic [NOUT-1:0] out_mask,
    input  logic            tristate,
    input  logic [SW-1:0]   settle_cycles,
    output logic [NOUT-1:0] gate_en,
    output logic            vco_en,
    output logic            osc_en
);
    logic run_req;
    logic gates_allowed;

    pd_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pd_n),
        .sync_out (run_req)
    );

    pd_fsm #(.SW(SW), .STOP_WAIT(STOP_WAIT)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_req       (run_req),
        .settle_cycles (settle_cycles),
        .gates_allowed (gates_allowed),
        .vco_en        (vco_en),
        .osc_en        (osc_en)
    );

    pd_gate_bank #(.NOUT(NOUT)) u_gates (
        .clk      (clk),
        .rst_n    (rst_n),
        .allow    (gates_allowed),
        .tristate (tristate),
        .out_mask (out_mask),
        .gate_en  (gate_en)
    );
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk #(
    parameter int NOUT = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tristate,
    input logic [NOUT-1:0] gate_en,
    input logic            vco_en,
    input logic            osc_en
);
    // R2: gates never move while the clock is high
    always @(gate_en) begin
        if (rst_n) begin
            assert_gate_on_low_R2: assert (!clk)
                else $error("gate changed with clk high");
        end
    end

    // R4
    assert_no_gate_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en || !vco_en) |-> (gate_en == '0));

    // R3
    assert_gates_closed_before_kill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_en) |-> ($past(gate_en) == '0 && !osc_en));

    // R5
    assert_closed_at_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en) |-> (gate_en == '0 && osc_en));

    // R7
    assert_tristate_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tristate && $past(tristate)) |-> (gate_en == '0));
endmodule

bind pwrdn_seq pwrdn_seq_chk #(.NOUT(NOUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tristate (tristate),
    .gate_en  (gate_en),
    .vco_en   (vco_en),
    .osc_en   (osc_en)
);

// File: tb/test_pwrdn_seq.sv
`timescale 1ns/1ps
module test_pwrdn_seq;
    localparam int NOUT = 8;
    localparam int SW   = 16;
    localparam int SETTLE = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pd_n = 1'b1;
    logic [NOUT-1:0] out_mask = '1;
    logic            tristate = 1'b0;
    logic [SW-1:0]   settle_cycles = SW'(SETTLE);
    logic [NOUT-1:0] gate_en;
    logic            vco_en, osc_en;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pwrdn_seq #(.NOUT(NOUT), .SW(SW), .STOP_WAIT(4)) i_pwrdn_seq (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .out_mask(out_mask),
        .tristate(tristate), .settle_cycles(settle_cycles),
        .gate_en(gate_en), .vco_en(vco_en), .osc_en(osc_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive point: 2 ns after a rising edge
    task automatic drive_slot();
        @(posedge clk); #2;
    endtask

    // sample point: 5 ns after a rising edge, before the falling edge
    task automatic sample_edge();
        @(posedge clk); #5;
    endtask

    task automatic t_reset();
        #5;
        check(gate_en == '0, "R10 gates", gate_en, 0);
        check(vco_en && osc_en, "R10 enables", {vco_en, osc_en}, 3);
        drive_slot(); drive_slot();
        rst_n = 1'b1;
        sample_edge(); sample_edge();
        check(gate_en == 8'hFF, "R6 gates after reset", gate_en, 8'hFF);
    endtask

    task automatic t_mask();
        drive_slot(); out_mask = 8'hA5;
        sample_edge();
        check(gate_en == 8'hA5, "R6 mask A5", gate_en, 8'hA5);
        drive_slot(); out_mask = 8'h3C;
        sample_edge();
        check(gate_en == 8'h3C, "R6 mask 3C", gate_en, 8'h3C);
        drive_slot(); out_mask = 8'hFF;
        sample_edge();
    endtask

    task automatic t_tristate();
        drive_slot(); tristate = 1'b1;
        sample_edge();
        check(gate_en == '0, "R7 tristate closes", gate_en, 0);
        sample_edge();
        check(gate_en == '0, "R7 tristate held", gate_en, 0);
        drive_slot(); tristate = 1'b0;
        sample_edge();
        check(gate_en == 8'hFF, "R7 release", gate_en, 8'hFF);
    endtask

    task automatic t_powerdown();
        int vco_off_at = -1;
        drive_slot(); pd_n = 1'b0;
        for (int k = 1; k <= 12; k++) begin
            sample_edge();
            if (k == 2) check(gate_en == 8'hFF, "R1 open after 2 edges", gate_en, 8'hFF);
            if (k == 3) check(gate_en == 8'hFF, "R1 open after 3 edges", gate_en, 8'hFF);
            if (k == 4) check(gate_en == '0, "R2 closed after 4 edges", gate_en, 0);
            if (k == 6) check(vco_en && osc_en && gate_en == '0, "R3 enables held while gated",
                              {vco_en, osc_en}, 3);
            if (vco_off_at < 0 && !vco_en) vco_off_at = k;
        end
        check(vco_off_at == 7, "R3 vco off edge", vco_off_at, 7);
        check(!osc_en, "R3 osc off", osc_en, 0);
    endtask

    task automatic t_ignore();
        drive_slot(); out_mask = 8'h0F; tristate = 1'b1;
        sample_edge();
        drive_slot(); tristate = 1'b0;
        for (int k = 0; k < 4; k++) begin
            sample_edge();
            check(gate_en == '0, "R9 gates stay closed in OFF", gate_en, 0);
        end
        drive_slot(); out_mask = 8'hFF;
    endtask

    task automatic t_wake();
        int on_at = -1;
        int gate_at = -1;
        drive_slot(); pd_n = 1'b1;
        for (int k = 1; k <= 15; k++) begin
            sample_edge();
            if (on_at < 0 && vco_en && osc_en) on_at = k;
            if (gate_at < 0 && gate_en != '0) gate_at = k;
        end
        check(on_at == 3, "R5 oscillator restart edge", on_at, 3);
        check(gate_at == SETTLE + 5, "R5 gates reopen edge", gate_at, SETTLE + 5);
        check(gate_en == 8'hFF, "R5 mask after wake", gate_en, 8'hFF);
    endtask

    task automatic t_abort();
        bit opened = 1'b0;
        drive_slot(); pd_n = 1'b0;
        repeat (10) sample_edge();
        check(!vco_en, "R8 setup off", vco_en, 0);
        drive_slot(); pd_n = 1'b1;
        repeat (3) @(posedge clk);
        #2 pd_n = 1'b0;
        for (int k = 0; k < 16; k++) begin
            sample_edge();
            if (gate_en != '0) opened = 1'b1;
        end
        check(!opened, "R8 gates never open", opened, 0);
        check(!vco_en && !osc_en, "R8 back to off", {vco_en, osc_en}, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_mask();
                t_tristate();
                t_powerdown();
                t_ignore();
                t_wake();
                t_abort();
                t_wake();
            end
            begin
                repeat (5000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule